// File: doc/BRIEF.md
# Double-Buffered Time-Slot Interchanger

This block reorders a byte-interleaved stream of time slots so that every output slot can carry the byte of any input slot. The mapping of one slot does not restrict any other. Two slots may even take the same source. Input bytes are stored in arrival order into one half of a two-half buffer. At the same time, the previous frame is read out of the other half. Each output slot has its own read address, which comes from a connection table.

The connection table keeps four maps: a working map and a protection map, each held in two copies (A and B). Software can fill one copy while another one is steering traffic. A frame sync input marks slot 0 of each incoming frame. The two buffer halves exchange roles only on a sync that arrives once the fill half is complete. At that exchange the selected map is copied into a live map. So neither a change of selection nor a table write can disturb a frame that is already being read out. The slot count is a parameter. The default of 12 is one channel of the full 576-slot fabric.

Top module: `slot_interchanger`

## Requirements
- R1: After reset, `out_valid` and `out_sync` are low. All four maps and the live map hold the identity mapping (output slot j takes input slot j).
- R2: The byte present with `in_sync` is stored as slot 0, and the following bytes are stored as slots 1, 2, and so on. Once NUM_SLOTS bytes are stored, further bytes without a sync are dropped until the next sync.
- R3: A sync that arrives when the fill half holds a complete frame exchanges the read half and the fill half. A sync that arrives earlier restarts filling at slot 0 in the same half, with no exchange and no new output frame.
- R4: Each exchange produces NUM_SLOTS consecutive output cycles with `out_valid` high. `out_sync` is high on output slot 0 only. Output slot j carries the completed frame's byte from input slot live[j], with any mapping allowed, including repeated sources. A byte being written in the exchange cycle never corrupts the frame being read.
- R5: The first output byte of a frame appears two clock edges after the edge that samples the exchanging sync. For frames sent back to back, the latency from input to output is NUM_SLOTS + 2 cycles.
- R6: `sel_protect` and `sel_copy_b` are sampled only on an exchange. A change between exchanges has no effect on the frame being read out.
- R7: A table write with `cfg_we` updates the map chosen by `cfg_map`. Bit 1 of `cfg_map` selects protection (1) or working (0), and bit 0 selects copy B (1) or copy A (0). The write sets entry `cfg_slot` to source `cfg_src`. It is accepted even for the map in use, but takes effect only from the next exchange. A write in the exchange cycle itself is not seen by that exchange.
- R8: A table write with `cfg_slot` >= NUM_SLOTS or `cfg_src` >= NUM_SLOTS is ignored.
- R9: `out_valid` is low whenever no frame is being read out. This covers the cycles after a frame's last slot when no new exchange has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Input slot byte |
| in_sync | input | 1 | Marks slot 0 of an input frame |
| sel_protect | input | 1 | 1 selects the protection map, sampled at exchange |
| sel_copy_b | input | 1 | 1 selects copy B, sampled at exchange |
| cfg_we | input | 1 | Table write strobe |
| cfg_map | input | 2 | Map to write: bit 1 protection, bit 0 copy B |
| cfg_slot | input | SLOT_W | Output slot entry to write |
| cfg_src | input | SLOT_W | Source input slot for that entry |
| out_data | output | DATA_W | Output slot byte |
| out_valid | output | 1 | Output byte is valid |
| out_sync | output | 1 | Marks output slot 0 |

## Verification
Frames carry a distinct byte in every slot, so any misrouted byte is visible. The identity map confirms ordering and latency. A reversed map reads slot 0 from the half being refilled in the exchange cycle, which exposes read/write collisions. A broadcast map (every output taking one source) tells a non-blocking lookup apart from a permutation-only one. Mid-frame changes of selection and table writes, including writes in the exchange cycle, show whether the live map is frozen at the right moment. An early sync and a sync-less run of extra bytes separate the exchange rule from plain sync-driven swapping.

// File: rtl/si_pkg.sv
package si_pkg;
  // map index encoding: bit 1 = protection, bit 0 = copy B
  typedef struct packed {
    logic protect;
    logic copy_b;
  } map_sel_t;

  localparam int NUM_MAPS = 4;
endpackage

// File: rtl/si_bank_buffer.sv
module si_bank_buffer #(
  parameter int SLOT_W = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = SLOT_W + 1,
  localparam int DEPTH  = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wbank,
  input  logic [SLOT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rbank,
  input  logic [SLOT_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, read-first: a read of a location written in the
  // same cycle returns the stored (previous frame) byte
  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
    rdata <= mem[{rbank, raddr}];
  end
endmodule

// File: rtl/si_connection_map.sv
module si_connection_map
  import si_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_map,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SLOT_W-1:0] cfg_src,
  input  logic              load,
  input  map_sel_t          load_sel,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SLOT_W-1:0] src_slot
);
  localparam logic [SLOT_W:0] N_EXT = (SLOT_W+1)'(NUM_SLOTS);

  logic [NUM_MAPS-1:0][NUM_SLOTS-1:0][SLOT_W-1:0] map_q;
  logic [NUM_SLOTS-1:0][SLOT_W-1:0]               live_q;
  logic                                           cfg_ok;

  assign cfg_ok = cfg_we && ({1'b0, cfg_slot} < N_EXT) && ({1'b0, cfg_src} < N_EXT);

  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < NUM_SLOTS; s++) map_q[m][s] <= SLOT_W'(s);
      end else if (cfg_ok && (cfg_map == 2'(m))) begin
        map_q[m][cfg_slot] <= cfg_src;
      end
    end
  end

  // live map: snapshot of the selected map, taken only at an exchange
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SLOTS; s++) live_q[s] <= SLOT_W'(s);
    end else if (load) begin
      live_q <= map_q[load_sel];
    end
  end

  assign src_slot = live_q[rd_slot];

  assert_live_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(live_q));
endmodule

// File: rtl/si_frame_ctrl.sv
module si_frame_ctrl #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 4,
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_sync,
  output logic              wr_en,
  output logic              wr_bank_o,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              swap,
  output logic              rd_run,
  output logic              rd_bank,
  output logic [SLOT_W-1:0] rd_slot
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NUM_SLOTS - 1);

  logic             wr_active;
  logic [CNT_W-1:0] wr_idx;
  logic             wr_bank;
  logic             fill_done;
  logic [SLOT_W-1:0] rd_idx;

  assign fill_done = wr_active && (wr_idx == FULL_CNT);
  assign swap      = in_sync && fill_done;
  assign wr_en     = in_sync || (wr_active && (wr_idx < FULL_CNT));
  assign wr_bank_o = swap ? ~wr_bank : wr_bank;
  assign wr_slot   = in_sync ? '0 : wr_idx[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_active <= 1'b0;
      wr_idx    <= '0;
      wr_bank   <= 1'b0;
    end else begin
      if (in_sync) begin
        wr_active <= 1'b1;
        wr_idx    <= CNT_W'(1);
      end else if (wr_en) begin
        wr_idx <= wr_idx + 1'b1;
      end
      if (swap) wr_bank <= ~wr_bank;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_run  <= 1'b0;
      rd_idx  <= '0;
      rd_bank <= 1'b1;
    end else if (swap) begin
      rd_run  <= 1'b1;
      rd_idx  <= '0;
      rd_bank <= wr_bank;
    end else if (rd_run) begin
      if (rd_idx == LAST_IDX) rd_run <= 1'b0;
      else rd_idx <= rd_idx + 1'b1;
    end
  end

  assign rd_slot = rd_idx;

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
    wr_idx <= FULL_CNT);
  assert_bank_exchange_R3: assert property (@(posedge clk) disable iff (rst)
    swap |=> (rd_bank == $past(wr_bank)));
  assert_halves_disjoint_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_run && !swap) |-> (wr_bank_o != rd_bank));
  assert_frame_end_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_run && (rd_idx == LAST_IDX) && !swap) |=> !rd_run);
endmodule

// File: rtl/slot_interchanger.sv
module slot_interchanger
  import si_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int DATA_W    = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sync,
  input  logic              sel_protect,
  input  logic              sel_copy_b,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_map,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SLOT_W-1:0] cfg_src,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sync
);
  logic              wr_en, wr_bank, swap, rd_run, rd_bank;
  logic [SLOT_W-1:0] wr_slot, rd_slot, src_slot;
  map_sel_t          sel;

  assign sel = '{protect: sel_protect, copy_b: sel_copy_b};

  si_frame_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) ctrl_i (
    .clk(clk), .rst(rst), .in_sync(in_sync),
    .wr_en(wr_en), .wr_bank_o(wr_bank), .wr_slot(wr_slot), .swap(swap),
    .rd_run(rd_run), .rd_bank(rd_bank), .rd_slot(rd_slot)
  );

  si_connection_map #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) cmap_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_map(cfg_map),
    .cfg_slot(cfg_slot), .cfg_src(cfg_src), .load(swap), .load_sel(sel),
    .rd_slot(rd_slot), .src_slot(src_slot)
  );

  si_bank_buffer #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) buf_i (
    .clk(clk), .we(wr_en), .wbank(wr_bank), .waddr(wr_slot), .wdata(in_data),
    .rbank(rd_bank), .raddr(src_slot), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sync  <= 1'b0;
    end else begin
      out_valid <= rd_run;
      out_sync  <= rd_run && (rd_slot == '0);
    end
  end

  assert_frame_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sync);
  assert_sync_valid_R4: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> out_valid);
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    swap |=> ##1 (out_valid && out_sync));
endmodule

// File: tb/slot_interchanger_tb.sv
module slot_interchanger_tb_top;
  localparam int  N      = 12;
  localparam int  SW     = $clog2(N);
  localparam time CLK_PD = 10ns;

  logic          clk = 0, rst = 1;
  logic [7:0]    in_data = '0;
  logic          in_sync = 0, sel_protect = 0, sel_copy_b = 0;
  logic          cfg_we = 0;
  logic [1:0]    cfg_map = '0;
  logic [SW-1:0] cfg_slot = '0, cfg_src = '0;
  logic [7:0]    out_data;
  logic          out_valid, out_sync;

  slot_interchanger #(.NUM_SLOTS(N), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_sync(in_sync),
    .sel_protect(sel_protect), .sel_copy_b(sel_copy_b), .cfg_we(cfg_we),
    .cfg_map(cfg_map), .cfg_slot(cfg_slot), .cfg_src(cfg_src),
    .out_data(out_data), .out_valid(out_valid), .out_sync(out_sync)
  );

  always #(CLK_PD/2) clk = ~clk;

  typedef struct { logic [7:0] d; bit s; int c; } exp_t;
  exp_t  q[$];
  int    checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  int   mmap [4][N];
  int   live [N];
  logic [7:0] m_wr [N];
  bit   m_active = 0;
  int   m_idx = 0;
  bit   p_we = 0; int p_map = 0, p_slot = 0, p_src = 0;
  bit   want_prot = 0, want_b = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].c < cyc) begin
        checks++; fails++;
        $display("FAIL %s R4 missing output: actual none expected data=%0h at cyc %0d", cur_req, q[0].d, q[0].c);
        void'(q.pop_front());
      end
      if (out_valid) begin
        checks++;
        if (q.size() == 0 || q[0].c != cyc) begin
          fails++;
          $display("FAIL %s R9 R5 unexpected valid: actual data=%0h at cyc %0d expected idle", cur_req, out_data, cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (out_data !== e.d || out_sync !== e.s) begin
            fails++;
            $display("FAIL %s R4 actual data=%0h sync=%0b expected data=%0h sync=%0b", cur_req, out_data, out_sync, e.d, e.s);
          end
        end
      end
    end
  end

  task automatic step(bit sync, logic [7:0] d);
    @(negedge clk);
    in_sync = sync; in_data = d;
    sel_protect = want_prot; sel_copy_b = want_b;
    cfg_we = p_we; cfg_map = 2'(p_map); cfg_slot = SW'(p_slot); cfg_src = SW'(p_src);
    // model: exchange uses the table before this cycle's write
    if (sync && m_active && m_idx == N) begin
      int sel = (want_prot ? 2 : 0) + (want_b ? 1 : 0);
      for (int j = 0; j < N; j++) live[j] = mmap[sel][j];
      for (int j = 0; j < N; j++) begin
        exp_t e;
        e.d = m_wr[live[j]]; e.s = (j == 0); e.c = cyc + 2 + j;
        q.push_back(e);
      end
    end
    if (p_we && p_slot < N && p_src < N) mmap[p_map][p_slot] = p_src;
    if (sync) begin m_wr[0] = d; m_idx = 1; m_active = 1; end
    else if (m_active && m_idx < N) begin m_wr[m_idx] = d; m_idx++; end
    p_we = 0;
  endtask

  task automatic send_frame(int f);
    for (int s = 0; s < N; s++) step(s == 0, 8'(f * 16 + s));
  endtask

  task automatic cfg(int m, int sl, int src);
    p_we = 1; p_map = m; p_slot = sl; p_src = src;
  endtask

  initial begin
    for (int m = 0; m < 4; m++) for (int s = 0; s < N; s++) mmap[m][s] = s;
    for (int s = 0; s < N; s++) live[s] = s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_sync !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual valid=%0b sync=%0b expected 0 0", out_valid, out_sync);
    end
    // R1 identity default, R5 latency via cycle stamps
    cur_req = "R1";
    for (int f = 0; f < 3; f++) send_frame(f);
    // R7: write reversed map to working A (in use) during a frame, incl. exchange cycle
    cur_req = "R7";
    for (int s = 0; s < N; s++) begin cfg(0, s, N - 1 - s); step(s == 0, 8'(3 * 16 + s)); end
    send_frame(4); send_frame(5);
    // R6: broadcast map in protect B; select changes mid-frame
    cur_req = "R6";
    for (int s = 0; s < N; s++) begin cfg(3, s, 3); step(s == 0, 8'(6 * 16 + s)); end
    for (int s = 0; s < N; s++) begin
      if (s == 6) begin want_prot = 1; want_b = 1; end
      step(s == 0, 8'(7 * 16 + s));
    end
    send_frame(8);
    for (int s = 0; s < N; s++) begin
      if (s == 4) begin want_prot = 0; want_b = 0; end
      if (s == 8) begin want_prot = 1; want_b = 1; end
      step(s == 0, 8'(9 * 16 + s));
    end
    // R8: out-of-range writes to the map in use
    cur_req = "R8";
    for (int s = 0; s < N; s++) begin
      if (s == 1) cfg(3, N, 1);
      if (s == 2) cfg(3, 0, N);
      if (s == 3) cfg(3, (1 << SW) - 1, 0);
      step(s == 0, 8'(10 * 16 + s));
    end
    send_frame(11); send_frame(12);
    // R3: early sync restarts fill without exchange
    cur_req = "R3";
    want_prot = 0; want_b = 0;
    for (int s = 0; s < 5; s++) step(s == 0, 8'(13 * 16 + s));
    send_frame(14); send_frame(15);
    // R2: extra bytes past a full frame are dropped; R9 idle gap
    cur_req = "R2";
    for (int s = 0; s < N + 7; s++) step(s == 0, 8'(s < N ? s + 32 : 8'hEE));
    repeat (N + 4) step(0, 8'h55);
    send_frame(1); send_frame(2);
    cur_req = "R9";
    repeat (N + 5) step(0, 8'h00);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R9 pending outputs: actual %0d expected 0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule